// File: doc/BRIEF.md
# Framed Serial Link Master with Buffer Polling

This block is the master end of a synchronous serial link to an attached controller. Each exchange is a fixed 13-clock frame. The master drives the clock, an active-high select and the outbound data line, and it samples the return line. A host inside the chip makes one request at a time: a data read, a data write or a status read. It gets back either the received byte with a one-cycle strobe, or, for a write, a strobe that says the byte was taken or has to be sent again.

Every frame starts with a one on the outbound line while the select is high. Two header bits follow: the direction and the target (data or status). Then come eight payload bits, most significant first, a single reply bit from the far end, and one idle clock. For a data read, the reply bit tells whether the far end's buffer held fresh data. A stale byte is dropped and produces no strobe.

After a frame that moved data, the select is pulled low for a configurable number of link clocks. After a status read it stays high, so status reads can follow one another with no gap. An elaboration option makes the block read the far end's buffer before every write or status command. The host cannot skip that poll.

Top module: `lsp_master`

## Requirements
- R1: After reset, `sclk`, `ss`, `mosi`, `busy` and all result strobes are low. While `busy` is low, `sclk` stays low.
- R2: Each frame has exactly 13 rising edges of `sclk`. `ss` is high at every one of them, and `mosi` is 1 at the first of them (the start bit).
- R3: The `mosi` value sampled at rising edge k (k = 0..12) is: k=1 direction (1 for read and status, 0 for write); k=2 target (1 for status, 0 for data); k=3..10 the write byte MSB first (all zero for reads); k=11 and k=12 zero.
- R4: `miso` sampled at rising edges 3..10 forms the received byte, MSB first. `miso` at rising edge 11 is the reply bit.
- R5: A data read with reply bit 0 gives a one-cycle `rx_valid` pulse, with the byte on `rx_data` and `rx_is_status` low.
- R6: A data read with reply bit 1 (stale) gives no `rx_valid` pulse.
- R7: A write with reply bit 0 gives a one-cycle `wr_ok` pulse. A write with reply bit 1 gives a one-cycle `wr_retry` pulse. At most one of `rx_valid`, `wr_ok` and `wr_retry` is high in any cycle.
- R8: A status read gives an `rx_valid` pulse with `rx_is_status` high and the received byte, whatever the reply bit.
- R9: After a data read or a write, `ss` is low at exactly GAP_CLKS rising edges of `sclk` before the block goes idle or starts its next frame.
- R10: After a status read, `ss` stays high. A following status read starts with no `sclk` rising edge at which `ss` is low.
- R11: A request is taken only while `busy` is low. `req_valid` raised while `busy` is high starts no frame.
- R12: `busy` rises in the cycle after a request is taken and falls only after the frame and any gap that follows it are complete.
- R13: With AUTO_POLL set, a write (`req_op`=1) or status (`req_op`=2) request is preceded by a data-read frame and its gap. The read's result is reported as in R5 and R6. Code 0 is a data read; code 3 behaves as a data read.
- R14: Within a frame, `sclk` has a period of 2*CLK_DIV system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken while idle |
| req_op | input | 2 | 0 data read, 1 write, 2 status read, 3 data read |
| req_wdata | input | DATA_W | Byte to send on a write |
| busy | output | 1 | High from acceptance until the frame and any gap are done |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| rx_data | output | DATA_W | Received byte |
| rx_is_status | output | 1 | Received byte came from a status read |
| wr_ok | output | 1 | Write accepted by the far end |
| wr_retry | output | 1 | Write rejected; reissue the byte |
| sclk | output | 1 | Link clock |
| ss | output | 1 | Active-high select |
| mosi | output | 1 | Master-to-far-end data |
| miso | input | 1 | Far-end-to-master data |

## Verification
The assertions assume that the far end changes `miso` only on falling `sclk` edges, so the bit sampled at each rising edge is settled. They also assume the host holds `req_op` to the codes listed above. The bench's far-end model follows both rules: it updates its return line only on falling edges of the link clock. The host requests it issues use only the listed codes. The only requests made while busy are the deliberate ones that test R11.

// File: rtl/lsp_pkg.sv
package lsp_pkg;
   timeunit 1ns;
   timeprecision 1ps;

   typedef enum logic [1:0] {
      OP_READ   = 2'd0,
      OP_WRITE  = 2'd1,
      OP_STATUS = 2'd2,
      OP_RSVD   = 2'd3
   } lsp_op_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FRAME = 2'd1,
      ST_GAP   = 2'd2
   } lsp_state_e;

   localparam int HDR_BITS  = 3;
   localparam int TAIL_BITS = 2;
endpackage

// File: rtl/lsp_tick_gen.sv
module lsp_tick_gen #(
   parameter int CLK_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam int CNT_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CLK_DIV - 1);

   generate
      if (CLK_DIV < 1) begin : g_bad_div
         $error("CLK_DIV must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;

   assign tick = run && (cnt == CNT_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (!run || tick) cnt <= '0;
      else                  cnt <= cnt + 1'b1;
   end

   generate
      if (CLK_DIV > 1) begin : g_spacing
         assert_tick_spacing_R14: assert property (@(posedge clk) disable iff (!rst_n)
            tick |=> !tick);
      end
   endgenerate
endmodule

// File: rtl/lsp_frame_shift.sv
module lsp_frame_shift #(
   parameter int DATA_W = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          load,
   input  logic [DATA_W+4:0]             load_word,
   input  logic                          rise,
   input  logic                          fall,
   input  logic                          miso,
   output logic                          mosi,
   output logic [$clog2(DATA_W+5)-1:0]   bit_idx,
   output logic [DATA_W-1:0]             rx_byte,
   output logic                          rx_flag
);
   timeunit 1ns;
   timeprecision 1ps;
   import lsp_pkg::*;

   localparam int FRAME_BITS = DATA_W + HDR_BITS + TAIL_BITS;
   localparam int IDX_W      = $clog2(FRAME_BITS);
   localparam int FIRST_RX   = HDR_BITS;
   localparam int FLAG_IDX   = HDR_BITS + DATA_W;
   localparam int LAST_IDX   = FRAME_BITS - 1;

   logic [FRAME_BITS-1:0] tx_sr;
   logic [DATA_W:0]       rx_sr;

   assign mosi    = tx_sr[FRAME_BITS-1];
   assign rx_byte = rx_sr[DATA_W:1];
   assign rx_flag = rx_sr[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sr   <= '0;
         rx_sr   <= '0;
         bit_idx <= '0;
      end else begin
         if (rise && bit_idx >= IDX_W'(FIRST_RX) && bit_idx <= IDX_W'(FLAG_IDX))
            rx_sr <= {rx_sr[DATA_W-1:0], miso};
         if (load) begin
            tx_sr   <= load_word;
            bit_idx <= '0;
         end else if (fall) begin
            tx_sr   <= {tx_sr[FRAME_BITS-2:0], 1'b0};
            bit_idx <= bit_idx + 1'b1;
         end
      end
   end

   assert_idx_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      bit_idx <= IDX_W'(LAST_IDX));
endmodule

// File: rtl/lsp_master.sv
module lsp_master #(
   parameter int DATA_W    = 8,
   parameter int CLK_DIV   = 4,
   parameter int GAP_CLKS  = 1,
   parameter bit AUTO_POLL = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_op,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              busy,
   output logic              rx_valid,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_is_status,
   output logic              wr_ok,
   output logic              wr_retry,
   output logic              sclk,
   output logic              ss,
   output logic              mosi,
   input  logic              miso
);
   timeunit 1ns;
   timeprecision 1ps;
   import lsp_pkg::*;

   localparam int FRAME_BITS = DATA_W + HDR_BITS + TAIL_BITS;
   localparam int IDX_W      = $clog2(FRAME_BITS);
   localparam int LAST_IDX   = FRAME_BITS - 1;
   localparam int GAP_W      = $clog2(GAP_CLKS + 1);

   generate
      if (DATA_W < 1)   begin : g_bad_width $error("DATA_W must be at least 1"); end
      if (GAP_CLKS < 1) begin : g_bad_gap   $error("GAP_CLKS must be at least 1"); end
   endgenerate

   function automatic logic [FRAME_BITS-1:0] frame_word(lsp_op_e op, logic [DATA_W-1:0] d);
      return {1'b1, op != OP_WRITE, op == OP_STATUS,
              (op == OP_WRITE) ? d : {DATA_W{1'b0}}, 2'b00};
   endfunction

   lsp_state_e            state;
   lsp_op_e               cur_op, pend_op, req_op_e;
   logic                  pend_valid, poll_first;
   logic [DATA_W-1:0]     pend_data;
   logic [GAP_W-1:0]      gap_cnt;
   logic                  sclk_q, ss_q, tick, rise, fall, frame_last, gap_done, accept;
   logic                  load;
   logic [FRAME_BITS-1:0] load_word;
   logic [IDX_W-1:0]      bit_idx;
   logic [DATA_W-1:0]     rx_byte;
   logic                  rx_flag;
   logic                  rx_valid_q, rx_is_status_q, wr_ok_q, wr_retry_q;
   logic [DATA_W-1:0]     rx_data_q;

   assign req_op_e = lsp_op_e'(req_op);

   generate
      if (AUTO_POLL) begin : g_poll
         assign poll_first = (req_op_e == OP_WRITE) || (req_op_e == OP_STATUS);
      end else begin : g_direct
         assign poll_first = 1'b0;
      end
   endgenerate

   lsp_tick_gen #(.CLK_DIV(CLK_DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .run(state != ST_IDLE), .tick(tick));

   assign rise       = tick && !sclk_q && (state == ST_FRAME);
   assign fall       = tick &&  sclk_q && (state == ST_FRAME);
   assign frame_last = fall && (bit_idx == IDX_W'(LAST_IDX));
   assign gap_done   = (state == ST_GAP) && tick && sclk_q && (gap_cnt == GAP_W'(GAP_CLKS));
   assign accept     = (state == ST_IDLE) && req_valid;

   always_comb begin
      load      = 1'b0;
      load_word = '0;
      if (accept) begin
         load      = 1'b1;
         load_word = frame_word(poll_first ? OP_READ : req_op_e, req_wdata);
      end else if (frame_last) begin
         load = 1'b1;
      end else if (gap_done && pend_valid) begin
         load      = 1'b1;
         load_word = frame_word(pend_op, pend_data);
      end
   end

   lsp_frame_shift #(.DATA_W(DATA_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .load(load), .load_word(load_word),
      .rise(rise), .fall(fall), .miso(miso), .mosi(mosi),
      .bit_idx(bit_idx), .rx_byte(rx_byte), .rx_flag(rx_flag));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state          <= ST_IDLE;
         sclk_q         <= 1'b0;
         ss_q           <= 1'b0;
         cur_op         <= OP_READ;
         pend_op        <= OP_READ;
         pend_valid     <= 1'b0;
         pend_data      <= '0;
         gap_cnt        <= '0;
         rx_valid_q     <= 1'b0;
         rx_is_status_q <= 1'b0;
         rx_data_q      <= '0;
         wr_ok_q        <= 1'b0;
         wr_retry_q     <= 1'b0;
      end else begin
         rx_valid_q <= 1'b0;
         wr_ok_q    <= 1'b0;
         wr_retry_q <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (req_valid) begin
                  state      <= ST_FRAME;
                  ss_q       <= 1'b1;
                  cur_op     <= poll_first ? OP_READ : req_op_e;
                  pend_valid <= poll_first;
                  pend_op    <= req_op_e;
                  pend_data  <= req_wdata;
               end
            end
            ST_FRAME: begin
               if (tick) sclk_q <= ~sclk_q;
               if (frame_last) begin
                  if (cur_op == OP_WRITE) begin
                     wr_ok_q    <= !rx_flag;
                     wr_retry_q <= rx_flag;
                  end else begin
                     rx_valid_q     <= (cur_op == OP_STATUS) || !rx_flag;
                     rx_is_status_q <= (cur_op == OP_STATUS);
                     rx_data_q      <= rx_byte;
                  end
                  if (cur_op == OP_STATUS) begin
                     state <= ST_IDLE;
                  end else begin
                     state   <= ST_GAP;
                     ss_q    <= 1'b0;
                     gap_cnt <= '0;
                  end
               end
            end
            ST_GAP: begin
               if (tick) sclk_q <= ~sclk_q;
               if (tick && !sclk_q) gap_cnt <= gap_cnt + 1'b1;
               if (gap_done) begin
                  if (pend_valid) begin
                     state      <= ST_FRAME;
                     ss_q       <= 1'b1;
                     cur_op     <= pend_op;
                     pend_valid <= 1'b0;
                  end else begin
                     state <= ST_IDLE;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy         = (state != ST_IDLE);
   assign sclk         = sclk_q;
   assign ss           = ss_q;
   assign rx_valid     = rx_valid_q;
   assign rx_data      = rx_data_q;
   assign rx_is_status = rx_is_status_q;
   assign wr_ok        = wr_ok_q;
   assign wr_retry     = wr_retry_q;

   assert_idle_clock_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !sclk);
   assert_select_at_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_FRAME && $rose(sclk)) |-> ss);
   assert_strobe_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);
   assert_stale_dropped_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && !rx_is_status) |-> !rx_flag);
   assert_retry_on_reject_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_retry |-> rx_flag);
   assert_results_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rx_valid, wr_ok, wr_retry}));
   assert_gap_select_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_GAP) |-> !ss);
   assert_busy_after_accept_R12: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> busy);
endmodule

// File: tb/lsp_slave_model.sv
module lsp_slave_model #(
   parameter int PERIOD_NS = 80
) (
   input  logic sclk,
   input  logic ss,
   input  logic mosi,
   output logic miso
);
   timeunit 1ns;
   timeprecision 1ps;

   logic [7:0]  txq[$];
   int          frames[$];
   int          gaps[$];
   logic [7:0]  stat_byte  = 8'h00;
   logic        stat_bit   = 1'b0;
   logic        reject_wr  = 1'b0;
   int          ss_err     = 0;
   int          per_err    = 0;
   int          low_edges  = 0;
   int          idx        = 0;
   logic        in_frame   = 1'b0;
   logic [12:0] rxw        = '0;
   logic [7:0]  cur        = '0;
   logic        curst      = 1'b0;
   realtime     last_rise  = 0;

   initial miso = 1'b0;

   always @(posedge sclk) begin
      if (in_frame) begin
         if (!ss) ss_err++;
         if ($realtime - last_rise != real'(PERIOD_NS)) per_err++;
         rxw = {rxw[11:0], mosi};
         idx++;
         if (idx == 12) begin
            in_frame  = 1'b0;
            frames.push_back(int'(rxw));
            low_edges = 0;
         end
      end else if (ss && mosi) begin
         in_frame = 1'b1;
         idx      = 0;
         rxw      = 13'd1;
         gaps.push_back(low_edges);
      end else if (!ss) begin
         low_edges++;
      end
      last_rise = $realtime;
   end

   always @(negedge sclk) begin
      if (in_frame) begin
         if (idx == 2) begin
            if (!rxw[1]) begin
               cur = 8'h00; curst = reject_wr;
            end else if (rxw[0]) begin
               cur = stat_byte; curst = stat_bit;
            end else if (txq.size() > 0) begin
               cur = txq.pop_front(); curst = 1'b0;
            end else begin
               cur = 8'hEE; curst = 1'b1;
            end
         end
         if (idx + 1 >= 3 && idx + 1 <= 10) miso = cur[10 - (idx + 1)];
         else if (idx + 1 == 11)             miso = curst;
         else                                miso = 1'b0;
      end else begin
         miso = 1'b0;
      end
   end
endmodule

// File: tb/lsp_master_test.sv
module lsp_master_test;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int DIV = 2;
   localparam int GAP = 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic       a_req_valid = 0, p_req_valid = 0;
   logic [1:0] a_req_op = 0, p_req_op = 0;
   logic [7:0] a_req_wdata = 0, p_req_wdata = 0;
   logic       a_busy, a_rx_valid, a_rx_is_status, a_wr_ok, a_wr_retry, a_sclk, a_ss, a_mosi, a_miso;
   logic       p_busy, p_rx_valid, p_rx_is_status, p_wr_ok, p_wr_retry, p_sclk, p_ss, p_mosi, p_miso;
   logic [7:0] a_rx_data, p_rx_data;

   lsp_master #(.DATA_W(8), .CLK_DIV(DIV), .GAP_CLKS(GAP), .AUTO_POLL(1'b0)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(a_req_valid), .req_op(a_req_op), .req_wdata(a_req_wdata),
      .busy(a_busy), .rx_valid(a_rx_valid), .rx_data(a_rx_data), .rx_is_status(a_rx_is_status),
      .wr_ok(a_wr_ok), .wr_retry(a_wr_retry), .sclk(a_sclk), .ss(a_ss), .mosi(a_mosi), .miso(a_miso));
   lsp_slave_model #(.PERIOD_NS(20 * DIV)) a_far (.sclk(a_sclk), .ss(a_ss), .mosi(a_mosi), .miso(a_miso));

   lsp_master #(.DATA_W(8), .CLK_DIV(DIV), .GAP_CLKS(GAP), .AUTO_POLL(1'b1)) uut_poll (
      .clk(clk), .rst_n(rst_n), .req_valid(p_req_valid), .req_op(p_req_op), .req_wdata(p_req_wdata),
      .busy(p_busy), .rx_valid(p_rx_valid), .rx_data(p_rx_data), .rx_is_status(p_rx_is_status),
      .wr_ok(p_wr_ok), .wr_retry(p_wr_retry), .sclk(p_sclk), .ss(p_ss), .mosi(p_mosi), .miso(p_miso));
   lsp_slave_model #(.PERIOD_NS(20 * DIV)) p_far (.sclk(p_sclk), .ss(p_ss), .mosi(p_mosi), .miso(p_miso));

   int n_chk = 0, n_fail = 0;
   int a_rxq[$], p_rxq[$];
   int a_ok = 0, a_retry = 0, p_ok = 0, p_retry = 0;
   logic a_busy_d = 0, p_busy_d = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   function automatic int fw(input int op, input logic [7:0] d);
      logic [12:0] w;
      w = {1'b1, op != 1, op == 2, (op == 1) ? d : 8'h00, 2'b00};
      return int'(w);
   endfunction

   // per-clock reference checks: result strobes, idle clock level, busy release
   always @(negedge clk) begin
      if (rst_n) begin
         if (a_rx_valid) a_rxq.push_back({23'd0, a_rx_is_status, a_rx_data});
         if (p_rx_valid) p_rxq.push_back({23'd0, p_rx_is_status, p_rx_data});
         if (a_wr_ok) a_ok++;
         if (a_wr_retry) a_retry++;
         if (p_wr_ok) p_ok++;
         if (p_wr_retry) p_retry++;
         if (!a_busy && a_sclk) chk(0, "R1 idle sclk", 1, 0);
         if (!p_busy && p_sclk) chk(0, "R1 idle sclk poll", 1, 0);
         if (a_busy_d && !a_busy && !a_ss)
            chk(a_far.low_edges == GAP, "R12 busy falls after gap", a_far.low_edges, GAP);
         if (p_busy_d && !p_busy && !p_ss)
            chk(p_far.low_edges == GAP, "R12 busy falls after gap poll", p_far.low_edges, GAP);
         a_busy_d = a_busy;
         p_busy_d = p_busy;
      end
   end

   task automatic issue(input bit poll, input logic [1:0] op, input logic [7:0] d);
      @(negedge clk);
      if (poll) begin p_req_valid = 1; p_req_op = op; p_req_wdata = d; end
      else      begin a_req_valid = 1; a_req_op = op; a_req_wdata = d; end
      @(negedge clk);
      p_req_valid = 0; a_req_valid = 0;
      chk(poll ? p_busy : a_busy, "R12 busy after accept", 0, 1);
      while (poll ? p_busy : a_busy) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   task automatic report;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
   end

   initial begin
      int v, nf;
      repeat (3) @(negedge clk);
      chk({a_sclk, a_ss, a_mosi, a_busy, a_rx_valid, a_wr_ok, a_wr_retry} == 0, "R1 reset outputs",
          {a_sclk, a_ss, a_mosi, a_busy, a_rx_valid, a_wr_ok, a_wr_retry}, 0);
      rst_n = 1;
      repeat (3) @(negedge clk);

      // R5 / R4 / R3: fresh data read
      a_far.txq.push_back(8'hA5);
      issue(0, 2'd0, 8'h00);
      v = a_far.frames.pop_front();
      chk(v == fw(0, 0), "R3 read frame bits", v, fw(0, 0));
      chk(a_rxq.size() == 1, "R5 one strobe for fresh read", a_rxq.size(), 1);
      v = (a_rxq.size() > 0) ? a_rxq.pop_front() : -1;
      chk(v == 32'h0A5, "R4 R5 received byte", v, 32'h0A5);

      // R6: stale read
      issue(0, 2'd0, 8'h00);
      chk(a_rxq.size() == 0, "R6 stale byte dropped", a_rxq.size(), 0);
      void'(a_far.frames.pop_front());

      // R7 accepted write, R9 gap before it
      issue(0, 2'd1, 8'h3C);
      v = a_far.frames.pop_front();
      chk(v == fw(1, 8'h3C), "R3 write frame bits", v, fw(1, 8'h3C));
      chk(a_far.gaps[$] == GAP, "R9 select low edges after data frame", a_far.gaps[$], GAP);
      chk(a_ok == 1 && a_retry == 0, "R7 write accepted", a_ok, 1);

      // R7 rejected write
      a_far.reject_wr = 1;
      issue(0, 2'd1, 8'hC3);
      a_far.reject_wr = 0;
      chk(a_retry == 1 && a_ok == 1, "R7 write retry", a_retry, 1);
      v = a_far.frames.pop_front();
      chk(v == fw(1, 8'hC3), "R3 rejected write frame bits", v, fw(1, 8'hC3));

      // R8 status read with reply bit set
      a_far.stat_byte = 8'h81; a_far.stat_bit = 1;
      issue(0, 2'd2, 8'h00);
      v = (a_rxq.size() > 0) ? a_rxq.pop_front() : -1;
      chk(v == 32'h181, "R8 status byte reported", v, 32'h181);
      v = a_far.frames.pop_front();
      chk(v == fw(2, 0), "R3 status frame bits", v, fw(2, 0));
      chk(a_ss == 1, "R10 select held after status", a_ss, 1);

      // R10 back-to-back status
      a_far.stat_byte = 8'h42; a_far.stat_bit = 0;
      issue(0, 2'd2, 8'h00);
      chk(a_far.gaps[$] == 0, "R10 no gap between status reads", a_far.gaps[$], 0);
      v = (a_rxq.size() > 0) ? a_rxq.pop_front() : -1;
      chk(v == 32'h142, "R8 second status byte", v, 32'h142);
      void'(a_far.frames.pop_front());

      // R11 request while busy is ignored
      a_far.txq.push_back(8'h5E);
      @(negedge clk);
      a_req_valid = 1; a_req_op = 2'd0;
      @(negedge clk);
      a_req_valid = 0;
      repeat (10) @(negedge clk);
      a_req_valid = 1; a_req_op = 2'd1; a_req_wdata = 8'h99;
      repeat (3) @(negedge clk);
      a_req_valid = 0;
      while (a_busy) @(negedge clk);
      repeat (2) @(negedge clk);
      nf = a_far.frames.size();
      chk(nf == 1, "R11 one frame only", nf, 1);
      chk(a_ok == 1, "R11 no write from ignored request", a_ok, 1);
      v = (a_rxq.size() > 0) ? a_rxq.pop_front() : -1;
      chk(v == 32'h05E, "R5 read after ignored request", v, 32'h05E);
      a_far.frames.delete();

      // R13 auto-poll before a write
      p_far.txq.push_back(8'h77);
      issue(1, 2'd1, 8'h12);
      nf = p_far.frames.size();
      chk(nf == 2, "R13 poll adds a frame", nf, 2);
      v = (nf > 0) ? p_far.frames.pop_front() : -1;
      chk(v == fw(0, 0), "R13 first frame is a read", v, fw(0, 0));
      v = (nf > 1) ? p_far.frames.pop_front() : -1;
      chk(v == fw(1, 8'h12), "R13 then the write", v, fw(1, 8'h12));
      chk(p_far.gaps[$] == GAP, "R9 gap between poll and write", p_far.gaps[$], GAP);
      v = (p_rxq.size() > 0) ? p_rxq.pop_front() : -1;
      chk(v == 32'h077, "R13 polled byte reported", v, 32'h077);
      chk(p_ok == 1, "R13 write accepted", p_ok, 1);

      // R13 auto-poll before status, stale poll
      p_far.stat_byte = 8'h0F; p_far.stat_bit = 0;
      issue(1, 2'd2, 8'h00);
      chk(p_far.frames.size() == 2, "R13 poll before status", p_far.frames.size(), 2);
      chk(p_rxq.size() == 1, "R6 stale poll dropped", p_rxq.size(), 1);
      v = (p_rxq.size() > 0) ? p_rxq.pop_front() : -1;
      chk(v == 32'h10F, "R8 status after poll", v, 32'h10F);

      // R2 / R14 link-level counters
      chk(a_far.ss_err + p_far.ss_err == 0, "R2 select high during frames", a_far.ss_err + p_far.ss_err, 0);
      chk(a_far.per_err + p_far.per_err == 0, "R14 sclk period", a_far.per_err + p_far.per_err, 0);
      report();
   end
endmodule